// File: doc/BRIEF.md
# Programmable Integer Clock Divider

This block divides a single input clock by an integer taken from a bit field of a control register. The register has a plain synchronous write port and a read port that always reflects its contents. A compile-time choice of encoding decides how the field value becomes a divisor. The choices are: value plus one, value as is, two to the power of the value, value as is with zero also meaning one, or a small table of field/divisor pairs. The result is clamped into a configured minimum/maximum window.

The divided output runs without gating at all times. A newly decoded divisor is adopted only when the running output period completes, so every period on the output is whole. Divide-by-1 forwards the input clock. Larger divisors come from a counter and a registered phase bit. An optional write mode uses the upper half of each write word as per-bit enables for the lower half. This lets a field be changed without reading the register first.

Top module: `clk_rate_div`

## Requirements
- R1: A write with `wr_en` high stores `wr_data` into the control register on that clock edge. `rd_data` shows the stored word. After reset the register reads 0.
- R2: Only the register bits under `FIELD_MASK` select the divisor. The default mask is 0x70. The field value is `(word & FIELD_MASK) >> FIELD_SHIFT`, and the default shift is the index of the lowest set bit of the mask, which is 4. All other bits have no effect on the output.
- R3: In the plus-one encoding the divisor is field + 1. Field 0 gives 1 and field 2 gives 3.
- R4: In the one-based encoding the divisor equals the field. A field of 0 is invalid and leaves the divisor unchanged.
- R5: In the power-of-two encoding the divisor is 2^field. Field 0 gives 1 and field 2 gives 4.
- R6: In the zero-as-one encoding the divisor equals the field, and field 0 gives divide-by-1.
- R7: In table encoding the field is matched against the table. By default field 0 selects 4 and field 1 selects 8. A field with no table entry leaves the divisor unchanged.
- R8: The divisor is clamped to no less than `MIN_DIV` and no more than `MAX_DIV`. The default window is 1 to (mask >> shift) + 1, which is 8.
- R9: With `HIWORD` set, bit i of the lower half is written only when bit 16+i of the write word is 1. The upper half of the register stays 0.
- R10: The divisor in use changes only at the last input cycle of an output period. Every output period has the high time that matches its own length.
- R11: At divide-by-1 the output equals the input clock. For a divisor d > 1 the output is high for ceil(d/2) input cycles and low for the rest of the d cycles.
- R12: During and after reset the divisor in use is `MIN_DIV`. With the default minimum, the output follows the input clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Clock to be divided; also clocks the register |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe for the control register |
| wr_data | input | REG_W | Write word (upper half holds bit enables in hiword mode) |
| rd_data | output | REG_W | Current control register contents |
| clk_out | output | 1 | Divided clock |

## Verification
The checker assumes that `MAX_DIV` is at least `MIN_DIV` and fits in `DIV_W` bits. It also assumes that any table entry lies in that window, so the active divisor is always inside the window. The hold check for hiword writes assumes that no other write lands in the cycle after an all-disabled write. The bench keeps to this by spacing every write 60 cycles apart and using only the default field placement. It measures every output period and high time with timestamps and checks their ratio continuously across each divisor switch.

// File: rtl/clk_rate_div_pkg.sv
`timescale 1ns/1ps
package clk_rate_div_pkg;

  typedef enum logic [2:0] {
    ENC_MINUS1    = 3'd0,
    ENC_ONE_BASED = 3'd1,
    ENC_POW2      = 3'd2,
    ENC_ZERO_ONE  = 3'd3,
    ENC_TABLE     = 3'd4
  } div_enc_e;

  // index of the lowest set bit of a mask (0 for an empty mask)
  function automatic int low_bit(input logic [63:0] m);
    for (int i = 0; i < 64; i++) begin
      if (m[i]) return i;
    end
    return 0;
  endfunction

  // number of bits needed to hold v
  function automatic int bits_for(input longint v);
    for (int i = 1; i < 63; i++) begin
      if ((longint'(1) << i) > v) return i;
    end
    return 63;
  endfunction

endpackage

// File: rtl/clk_rate_div_ctlreg.sv
`timescale 1ns/1ps
module clk_rate_div_ctlreg #(
  parameter int              REG_W   = 32,
  parameter bit              HIWORD  = 1'b0,
  parameter logic [REG_W-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] ctl_q
);

  localparam int HALF = REG_W / 2;

  logic [REG_W-1:0] ctl_d;

  generate
    if (HIWORD) begin : g_hiword
      always_comb begin
        ctl_d = '0;
        for (int i = 0; i < HALF; i++) begin
          ctl_d[i] = wr_data[HALF + i] ? wr_data[i] : ctl_q[i];
        end
      end
    end else begin : g_full
      always_comb begin
        ctl_d = wr_data;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= RST_VAL;
    end else if (wr_en) begin
      ctl_q <= ctl_d;
    end
  end

endmodule

// File: rtl/clk_rate_div_decode.sv
`timescale 1ns/1ps
module clk_rate_div_decode
  import clk_rate_div_pkg::*;
#(
  parameter div_enc_e          ENC         = ENC_MINUS1,
  parameter int                REG_W       = 32,
  parameter logic [REG_W-1:0]  FIELD_MASK  = 32'h70,
  parameter int                FIELD_SHIFT = 4,
  parameter int                FLD_W       = 3,
  parameter int                DIV_W       = 8,
  parameter int                MIN_DIV     = 1,
  parameter int                MAX_DIV     = 8,
  parameter int                TBL_N       = 2,
  parameter logic [TBL_N*DIV_W-1:0] TBL_DIV = {8'd8, 8'd4},
  parameter logic [TBL_N*DIV_W-1:0] TBL_FLD = {8'd1, 8'd0}
) (
  input  logic [REG_W-1:0] ctl_word,
  output logic [DIV_W-1:0] div_o,
  output logic             vld_o
);

  localparam int RW = DIV_W + 1;

  logic [FLD_W-1:0] fld;
  logic [RW-1:0]    raw;

  always_comb begin
    fld   = FLD_W'((ctl_word & FIELD_MASK) >> FIELD_SHIFT);
    raw   = RW'(1);
    vld_o = 1'b1;
    case (ENC)
      ENC_MINUS1: begin
        raw = RW'(fld) + RW'(1);
      end
      ENC_ONE_BASED: begin
        raw   = RW'(fld);
        vld_o = (fld != '0);
      end
      ENC_POW2: begin
        if (int'(fld) >= DIV_W) raw = RW'(MAX_DIV);
        else                    raw = RW'(1) << fld;
      end
      ENC_ZERO_ONE: begin
        raw = (fld == '0) ? RW'(1) : RW'(fld);
      end
      default: begin
        vld_o = 1'b0;
        for (int i = 0; i < TBL_N; i++) begin
          if (!vld_o && (TBL_FLD[i*DIV_W +: DIV_W] == DIV_W'(fld))) begin
            raw   = RW'(TBL_DIV[i*DIV_W +: DIV_W]);
            vld_o = 1'b1;
          end
        end
      end
    endcase

    if (raw < RW'(MIN_DIV))      div_o = DIV_W'(MIN_DIV);
    else if (raw > RW'(MAX_DIV)) div_o = DIV_W'(MAX_DIV);
    else                         div_o = DIV_W'(raw);
  end

endmodule

// File: rtl/clk_rate_div.sv
`timescale 1ns/1ps
module clk_rate_div
  import clk_rate_div_pkg::*;
#(
  parameter div_enc_e          ENC         = ENC_MINUS1,
  parameter int                REG_W       = 32,
  parameter logic [REG_W-1:0]  FIELD_MASK  = 32'h70,
  parameter int                FIELD_SHIFT = low_bit(64'(FIELD_MASK)),
  parameter int                DIV_W       = 8,
  parameter int                MIN_DIV     = 1,
  parameter int                MAX_DIV     = int'(FIELD_MASK >> FIELD_SHIFT) + 1,
  parameter bit                HIWORD      = 1'b0,
  parameter int                TBL_N       = 2,
  parameter logic [TBL_N*DIV_W-1:0] TBL_DIV = {8'd8, 8'd4},
  parameter logic [TBL_N*DIV_W-1:0] TBL_FLD = {8'd1, 8'd0},
  parameter logic [REG_W-1:0]  RST_VAL     = '0
) (
  input  logic             clk_in,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             clk_out
);

  localparam int FLD_W = bits_for(longint'(FIELD_MASK >> FIELD_SHIFT));

  // reset release synchronizer
  logic [1:0] rs_q;
  logic       rst_sync_n;

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  // control register and field decode
  logic [REG_W-1:0] ctl_q;
  logic [DIV_W-1:0] dec_div;
  logic             dec_vld;

  clk_rate_div_ctlreg #(
    .REG_W   (REG_W),
    .HIWORD  (HIWORD),
    .RST_VAL (RST_VAL)
  ) u_ctlreg (
    .clk     (clk_in),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .ctl_q   (ctl_q)
  );

  clk_rate_div_decode #(
    .ENC         (ENC),
    .REG_W       (REG_W),
    .FIELD_MASK  (FIELD_MASK),
    .FIELD_SHIFT (FIELD_SHIFT),
    .FLD_W       (FLD_W),
    .DIV_W       (DIV_W),
    .MIN_DIV     (MIN_DIV),
    .MAX_DIV     (MAX_DIV),
    .TBL_N       (TBL_N),
    .TBL_DIV     (TBL_DIV),
    .TBL_FLD     (TBL_FLD)
  ) u_decode (
    .ctl_word (ctl_q),
    .div_o    (dec_div),
    .vld_o    (dec_vld)
  );

  assign rd_data = ctl_q;

  // pending divisor: follows the decoder while its encoding is valid
  logic [DIV_W-1:0] tgt_q;

  always_ff @(posedge clk_in or negedge rst_sync_n) begin
    if (!rst_sync_n)  tgt_q <= DIV_W'(MIN_DIV);
    else if (dec_vld) tgt_q <= dec_div;
  end

  // period counter, active divisor and output phase
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] act_q, act_d;
  logic             ph_q, ph_d;
  logic             wrap;
  logic [DIV_W:0]   hi_len;

  always_comb begin
    wrap   = (cnt_q == act_q - DIV_W'(1));
    cnt_d  = wrap ? '0 : cnt_q + DIV_W'(1);
    act_d  = wrap ? tgt_q : act_q;
    hi_len = ({1'b0, act_d} + (DIV_W+1)'(1)) >> 1;
    ph_d   = ({1'b0, cnt_d} < hi_len);
  end

  always_ff @(posedge clk_in or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cnt_q <= '0;
      act_q <= DIV_W'(MIN_DIV);
      ph_q  <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
      ph_q  <= ph_d;
    end
  end

  assign clk_out = (act_q == DIV_W'(1)) ? clk_in : ph_q;

endmodule

// File: rtl/clk_rate_div_chk.sv
`timescale 1ns/1ps
module clk_rate_div_chk #(
  parameter int REG_W   = 32,
  parameter int DIV_W   = 8,
  parameter int MIN_DIV = 1,
  parameter int MAX_DIV = 8,
  parameter bit HIWORD  = 1'b0
) (
  input logic             clk_in,
  input logic             rst_n,
  input logic             wr_en,
  input logic [REG_W-1:0] wr_data,
  input logic [REG_W-1:0] rd_data,
  input logic [DIV_W-1:0] cnt_q,
  input logic [DIV_W-1:0] act_q,
  input logic             ph_q
);

  localparam int HALF = REG_W / 2;

  AST_DIV_WINDOW: assert property (@(posedge clk_in) disable iff (!rst_n)
    (act_q >= DIV_W'(MIN_DIV)) && (act_q <= DIV_W'(MAX_DIV))); // R8

  AST_CNT_IN_PERIOD: assert property (@(posedge clk_in) disable iff (!rst_n)
    cnt_q < act_q); // R10

  AST_SWITCH_AT_END: assert property (@(posedge clk_in) disable iff (!rst_n)
    (cnt_q != act_q - DIV_W'(1)) |=> $stable(act_q)); // R10

  AST_PERIOD_OPENS_HIGH: assert property (@(posedge clk_in) disable iff (!rst_n)
    (act_q > DIV_W'(1) && cnt_q == '0) |-> ph_q); // R11

  AST_PERIOD_CLOSES_LOW: assert property (@(posedge clk_in) disable iff (!rst_n)
    (act_q > DIV_W'(1) && cnt_q == act_q - DIV_W'(1)) |-> !ph_q); // R11

  AST_HIWORD_NO_ENABLE: assert property (@(posedge clk_in) disable iff (!rst_n)
    (HIWORD && wr_en && wr_data[REG_W-1:HALF] == '0) |=> $stable(rd_data)); // R9

endmodule

bind clk_rate_div clk_rate_div_chk #(
  .REG_W   (REG_W),
  .DIV_W   (DIV_W),
  .MIN_DIV (MIN_DIV),
  .MAX_DIV (MAX_DIV),
  .HIWORD  (HIWORD)
) u_chk (
  .clk_in  (clk_in),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .wr_data (wr_data),
  .rd_data (rd_data),
  .cnt_q   (cnt_q),
  .act_q   (act_q),
  .ph_q    (ph_q)
);

// File: tb/clk_rate_div_tb.sv
`timescale 1ns/1ps
module clk_rate_div_tb;
  import clk_rate_div_pkg::*;

  localparam int NI = 7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd [NI];
  logic [NI-1:0] clk_o;

  always #2 clk = ~clk;   // 250 MHz

  realtime last_rise [NI];
  realtime last_hi   [NI];
  realtime per_ns    [NI];
  realtime hi_ns     [NI];
  int      bad       [NI];
  bit      mon_en = 1'b0;
  bit      done   = 1'b0;

  int n_chk  = 0;
  int n_fail = 0;
  logic [31:0] mreg [NI];
  int          expd [NI];

  // expected high time for a period of p ns (R11)
  function automatic realtime hi_of(input realtime p);
    int d;
    d = int'(p / 4.0);
    return (d == 1) ? 2.0 : 4.0 * ((d + 1) / 2);
  endfunction

  // instance map: 0 plus-one, 1 one-based, 2 power-of-two, 3 zero-as-one,
  // 4 table, 5 plus-one with hiword writes, 6 plus-one with window 3..6
  generate
    for (genvar g = 0; g < NI; g++) begin : g_dut
      localparam div_enc_e E = (g == 1) ? ENC_ONE_BASED :
                               (g == 2) ? ENC_POW2 :
                               (g == 3) ? ENC_ZERO_ONE :
                               (g == 4) ? ENC_TABLE : ENC_MINUS1;
      clk_rate_div #(
        .ENC     (E),
        .MIN_DIV ((g == 6) ? 3 : 1),
        .MAX_DIV ((g == 6) ? 6 : 8),
        .HIWORD  (g == 5)
      ) u_dut (
        .clk_in  (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd[g]),
        .clk_out (clk_o[g])
      );

      always @(posedge clk_o[g]) begin
        if (mon_en) begin
          if (last_rise[g] >= 0.0) begin
            per_ns[g] = $realtime - last_rise[g];
            if (last_hi[g] > 0.0 && last_hi[g] != hi_of(per_ns[g])) bad[g]++;
          end
          last_rise[g] = $realtime;
          last_hi[g]   = 0.0;
        end
      end

      always @(negedge clk_o[g]) begin
        if (mon_en && last_rise[g] >= 0.0) begin
          last_hi[g] = $realtime - last_rise[g];
          hi_ns[g]   = last_hi[g];
        end
      end
    end
  endgenerate

  function automatic int model(input int g, input logic [31:0] r, input int prev);
    int f, d, mn, mx;
    f  = int'((r >> 4) & 32'h7);
    mn = (g == 6) ? 3 : 1;
    mx = (g == 6) ? 6 : 8;
    case (g)
      1: begin if (f == 0) return prev; d = f; end
      2: d = 1 << f;
      3: d = (f == 0) ? 1 : f;
      4: begin
        if (f == 0)      d = 4;
        else if (f == 1) d = 8;
        else return prev;
      end
      default: d = f + 1;
    endcase
    if (d < mn) d = mn;
    if (d > mx) d = mx;
    return d;
  endfunction

  function automatic string tag_of(input int g);
    case (g)
      0: return "R3 R2";
      1: return "R4";
      2: return "R5 R8";
      3: return "R6";
      4: return "R7";
      5: return "R9";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int g,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s inst %0d: actual %0d expected %0d", req, g, act, exp);
    end
  endtask

  task automatic check_all();
    for (int g = 0; g < NI; g++) begin
      chk(rd[g] == mreg[g], (g == 5) ? "R9" : "R1", g, rd[g], mreg[g]);
      chk(int'(per_ns[g]) == 4 * expd[g], tag_of(g), g, int'(per_ns[g]), 4 * expd[g]);
      chk(hi_ns[g] == hi_of(4.0 * expd[g]), "R11", g, int'(hi_ns[g]),
          int'(hi_of(4.0 * expd[g])));
    end
  endtask

  task automatic do_write(input logic [31:0] d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
    for (int g = 0; g < NI; g++) begin
      if (g == 5) mreg[g] = {16'h0, (mreg[g][15:0] & ~d[31:16]) | (d[15:0] & d[31:16])};
      else        mreg[g] = d;
      expd[g] = model(g, mreg[g], expd[g]);
    end
    repeat (60) @(negedge clk);
    check_all();
  endtask

  initial begin
    for (int g = 0; g < NI; g++) begin
      last_rise[g] = -1.0;
      last_hi[g]   = 0.0;
      per_ns[g]    = 0.0;
      hi_ns[g]     = 0.0;
      bad[g]       = 0;
      mreg[g]      = '0;
      expd[g]      = model(g, 32'h0, (g == 6) ? 3 : 1);
    end

    // R12: reset state
    repeat (3) @(posedge clk);
    #1;
    chk(clk_o[0] == 1'b1, "R12", 0, clk_o[0], 1);
    @(negedge clk);
    #1;
    chk(clk_o[0] == 1'b0, "R12", 0, clk_o[0], 0);
    chk(clk_o[6] == 1'b1, "R12", 6, clk_o[6], 1);
    chk(rd[0] == 32'h0, "R1", 0, rd[0], 0);
    @(negedge clk);
    rst_n  = 1'b1;
    mon_en = 1'b1;
    repeat (60) @(negedge clk);
    check_all();

    // field sweeps up and down with junk outside the field (R2)
    for (int f = 0; f < 8; f++)  do_write({16'hFFFF, 16'hA50F | 16'(f << 4)});
    for (int f = 7; f >= 0; f--) do_write({16'hFFFF, 16'hA50F | 16'(f << 4)});

    // R9: hiword writes with no enables, then a single enabled bit
    do_write({16'h0000, 16'h0050});
    do_write({16'h0020, 16'h0060});

    // R10: every observed period was whole
    for (int g = 0; g < NI; g++) chk(bad[g] == 0, "R10", g, bad[g], 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule